// File: doc/BRIEF.md
# Result Packet Dispatcher with Round-Robin Bus

This block collects results from eight compute units and delivers them as operand packets to the units that consume them. Each result arrives on a per-source valid/ready port carrying one data value and a list of up to four destination tags. A destination tag names a target unit, an instruction slot in that unit, an iteration offset and an operand index.

Each source owns a four-entry result queue. The head entry of a queue is expanded into one packet per destination, in list order. A single shared bus carries one packet per cycle. It picks among non-empty queues in round-robin order. The winning packet is captured in a bus register and appears on the target unit's delivery port one cycle later, as a single-cycle valid pulse. Because of this register, a consumer never sees a value in the cycle that directly follows the cycle in which the value was accepted.

Back-pressure follows the usual valid/ready rules. A source holds `res_valid` and its payload steady until it samples `res_ready` high at a rising edge. `res_ready` depends only on whether that source's queue is full. It never depends on `res_valid`, and it does not account for a pop in the same cycle. The delivery side has no ready: consumers must always take a pulse.

Top module: `pkt_dispatch`

## Requirements
- R1: After reset, and after a reset applied while results are queued, every `res_ready` is high, no `dlv_valid` bit rises, and queued results are discarded.
- R2: A result is accepted on a rising edge where `res_valid[s]` and `res_ready[s]` are both high. `res_ready[s]` is low exactly while queue `s` holds 4 results. A result held under low ready is neither lost nor duplicated.
- R3: A destination tag is 12 bits wide: unit in bits [11:9], slot in [8:4], iteration offset in [3:2] and operand index in [1:0]. Destination `k` of source `s` sits at `res_dst[(s*4+k)*12 +: 12]`. A packet raises `dlv_valid[unit]` and carries the result value, slot, offset and operand on that unit's slice of the delivery ports.
- R4: `res_ncm1[s]` (2 bits) holds the destination count minus one. A result yields exactly that many plus one packets, delivered in ascending list index.
- R5: With the bus otherwise idle, destination `k` of a result accepted at edge `e` is delivered in the cycle after edge `e+1+k`. Nothing is delivered in the cycle directly after edge `e`.
- R6: At most one `dlv_valid` bit is high in any cycle.
- R7: Grants rotate round-robin among non-empty queues. The search starts one past the last granted source and, after reset, at source 0. Every packet grant, including one in the middle of an expansion, moves the pointer.
- R8: Under sustained contention, every accepted result from every source is delivered, in acceptance order for that source.
- R9: Each packet produces exactly one single-cycle delivery pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 8 | Result valid, one bit per source |
| res_ready | output | 8 | Result ready (queue not full), one bit per source |
| res_data | input | 256 | Result values, 32 bits per source |
| res_ncm1 | input | 16 | Destination count minus one, 2 bits per source |
| res_dst | input | 384 | Destination tags, 4 x 12 bits per source |
| dlv_valid | output | 8 | Operand delivery pulse, one bit per target unit |
| dlv_data | output | 256 | Delivered value, 32 bits per unit |
| dlv_slot | output | 40 | Instruction slot, 5 bits per unit |
| dlv_iter | output | 16 | Iteration offset, 2 bits per unit |
| dlv_opnd | output | 16 | Operand index, 2 bits per unit |

## Verification
A wrong queue pointer or count appears as lost, repeated or reordered values from one source. It is visible at the delivery ports within one arbitration round, at most eight cycles once the queue is backed up. A wrong expansion index appears on the very next pulse from that source as a wrong target unit or field. A broken round-robin pointer shows up as a skipped or repeated source in the stream of back-to-back pulses under saturation. A missing or extra bus stage moves the first pulse of an isolated result off its expected cycle, which is caught on the first packet.

// File: rtl/pkt_dispatch_pkg.sv
package pkt_dispatch_pkg;
  localparam int UNIT_W = 3;
  localparam int SLOT_W = 5;
  localparam int ITER_W = 2;
  localparam int OPND_W = 2;
  localparam int TAG_W  = UNIT_W + SLOT_W + ITER_W + OPND_W;

  typedef struct packed {
    logic [UNIT_W-1:0] unit;
    logic [SLOT_W-1:0] slot;
    logic [ITER_W-1:0] iter;
    logic [OPND_W-1:0] opnd;
  } dst_tag_t;
endpackage

// File: rtl/pkd_srcq.sv
module pkd_srcq
  import pkt_dispatch_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MAXD   = 4,
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(MAXD),
  localparam int PW    = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  push,
  input  logic [DATA_W-1:0]     in_data,
  input  logic [CNT_W-1:0]      in_ncm1,
  input  logic [MAXD*TAG_W-1:0] in_dst,
  output logic                  full,
  output logic                  empty,
  input  logic                  adv,
  output logic [DATA_W-1:0]     hd_data,
  output dst_tag_t              hd_tag,
  output logic                  hd_last
);
  logic [DATA_W-1:0]     mem_d [DEPTH];
  logic [CNT_W-1:0]      mem_c [DEPTH];
  logic [MAXD*TAG_W-1:0] mem_t [DEPTH];
  logic [PW-1:0]         wp, rp;
  logic [PW:0]           cnt;
  logic [CNT_W-1:0]      idx;
  logic                  pop;

  assign full    = (cnt == (PW+1)'(DEPTH));
  assign empty   = (cnt == '0);
  assign hd_data = mem_d[rp];
  assign hd_tag  = dst_tag_t'(mem_t[rp][int'(idx)*TAG_W +: TAG_W]);
  assign hd_last = (idx == mem_c[rp]);
  assign pop     = adv && hd_last;

  always_ff @(posedge clk) begin
    if (push) begin
      mem_d[wp] <= in_data;
      mem_c[wp] <= in_ncm1;
      mem_t[wp] <= in_dst;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      idx <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (adv) idx <= hd_last ? '0 : idx + 1'b1;
    end
  end

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (PW+1)'(DEPTH));
  p_adv_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> !empty);
  p_idx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(idx));
  p_idx_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !empty |-> idx <= mem_c[rp]);
endmodule

// File: rtl/pkd_rr_arb.sv
module pkd_rr_arb #(
  parameter int N = 8,
  localparam int PTR_W = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  logic [PTR_W-1:0] ptr;
  logic [PTR_W-1:0] gidx;
  logic             found;

  always_comb begin
    gnt   = '0;
    gidx  = '0;
    found = 1'b0;
    for (int k = 1; k <= N; k++) begin
      int j;
      j = (int'(ptr) + k) % N;
      if (!found && req[j]) begin
        gnt[j] = 1'b1;
        gidx   = PTR_W'(j);
        found  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     ptr <= PTR_W'(N-1);
    else if (found) ptr <= gidx;
  end

  p_gnt_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  p_gnt_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);
  p_gnt_any_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> (|gnt));
endmodule

// File: rtl/pkt_dispatch.sv
module pkt_dispatch
  import pkt_dispatch_pkg::*;
#(
  parameter int NSRC   = 8,
  parameter int DATA_W = 32,
  parameter int MAXD   = 4,
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(MAXD)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NSRC-1:0]             res_valid,
  output logic [NSRC-1:0]             res_ready,
  input  logic [NSRC*DATA_W-1:0]      res_data,
  input  logic [NSRC*CNT_W-1:0]       res_ncm1,
  input  logic [NSRC*MAXD*TAG_W-1:0]  res_dst,
  output logic [NSRC-1:0]             dlv_valid,
  output logic [NSRC*DATA_W-1:0]      dlv_data,
  output logic [NSRC*SLOT_W-1:0]      dlv_slot,
  output logic [NSRC*ITER_W-1:0]      dlv_iter,
  output logic [NSRC*OPND_W-1:0]      dlv_opnd
);
  logic [NSRC-1:0]   full, empty, gnt, last;
  logic [DATA_W-1:0] hd_data [NSRC];
  dst_tag_t          hd_tag  [NSRC];
  logic [DATA_W-1:0] sel_data;
  dst_tag_t          sel_tag;
  logic              bus_v;
  logic [DATA_W-1:0] bus_data;
  dst_tag_t          bus_tag;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    pkd_srcq #(.DATA_W(DATA_W), .MAXD(MAXD), .DEPTH(DEPTH)) u_q (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (res_valid[s] && !full[s]),
      .in_data (res_data[s*DATA_W +: DATA_W]),
      .in_ncm1 (res_ncm1[s*CNT_W +: CNT_W]),
      .in_dst  (res_dst[s*MAXD*TAG_W +: MAXD*TAG_W]),
      .full    (full[s]),
      .empty   (empty[s]),
      .adv     (gnt[s]),
      .hd_data (hd_data[s]),
      .hd_tag  (hd_tag[s]),
      .hd_last (last[s])
    );
  end

  assign res_ready = ~full;

  pkd_rr_arb #(.N(NSRC)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (~empty),
    .gnt   (gnt)
  );

  always_comb begin
    sel_data = '0;
    sel_tag  = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (gnt[s]) begin
        sel_data = sel_data | hd_data[s];
        sel_tag  = sel_tag | hd_tag[s];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_v    <= 1'b0;
      bus_data <= '0;
      bus_tag  <= '0;
    end else begin
      bus_v <= |gnt;
      if (|gnt) begin
        bus_data <= sel_data;
        bus_tag  <= sel_tag;
      end
    end
  end

  for (genvar u = 0; u < NSRC; u++) begin : g_dlv
    assign dlv_valid[u]                    = bus_v && (bus_tag.unit == UNIT_W'(u));
    assign dlv_data[u*DATA_W +: DATA_W]    = bus_data;
    assign dlv_slot[u*SLOT_W +: SLOT_W]    = bus_tag.slot;
    assign dlv_iter[u*ITER_W +: ITER_W]    = bus_tag.iter;
    assign dlv_opnd[u*OPND_W +: OPND_W]    = bus_tag.opnd;
  end

  p_dlv_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dlv_valid));
  p_no_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (&empty) |=> !(|dlv_valid));
  p_ready_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_ready[0] && !gnt[0]) |=> !res_ready[0]);
endmodule

// File: tb/sim_pkt_dispatch.sv
module sim_pkt_dispatch;
  localparam int NSRC = 8;
  localparam int DW   = 32;
  localparam int TW   = 12;
  localparam int MAXD = 4;

  typedef struct packed {
    logic [2:0]       src;
    logic [1:0]       ncm1;
    logic [31:0]      data;
    logic [4*TW-1:0]  dst;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{3'd0, 2'd0, 32'h1111_0001, {12'h0, 12'h0, 12'h0, {3'd4,5'd17,2'd2,2'd1}}},
    '{3'd3, 2'd1, 32'hA5A5_0003, {12'h0, 12'h0, {3'd7,5'd0,2'd0,2'd0}, {3'd0,5'd31,2'd3,2'd3}}},
    '{3'd7, 2'd3, 32'hDEAD_0007, {{3'd3,5'd30,2'd3,2'd1}, {3'd6,5'd9,2'd0,2'd2},
                                  {3'd1,5'd3,2'd1,2'd1}, {3'd1,5'd2,2'd1,2'd0}}},
    '{3'd5, 2'd2, 32'h0000_0000, {12'h0, {3'd0,5'd1,2'd0,2'd0}, {3'd2,5'd12,2'd2,2'd3},
                                  {3'd5,5'd5,2'd1,2'd1}}},
    '{3'd2, 2'd0, 32'hFFFF_FFFF, {12'h0, 12'h0, 12'h0, {3'd7,5'd31,2'd3,2'd3}}}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC-1:0]         res_valid = '0;
  logic [NSRC-1:0]         res_ready;
  logic [NSRC*DW-1:0]      res_data = '0;
  logic [NSRC*2-1:0]       res_ncm1 = '0;
  logic [NSRC*MAXD*TW-1:0] res_dst = '0;
  logic [NSRC-1:0]         dlv_valid;
  logic [NSRC*DW-1:0]      dlv_data;
  logic [NSRC*5-1:0]       dlv_slot;
  logic [NSRC*2-1:0]       dlv_iter;
  logic [NSRC*2-1:0]       dlv_opnd;

  pkt_dispatch u0 (.*);

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_bad = 0;
  int multi_hits = 0;

  int       lg_n = 0;
  int       lg_cyc  [1024];
  int       lg_unit [1024];
  logic [31:0] lg_data [1024];
  logic [11:0] lg_fld  [1024];

  always @(negedge clk) begin
    int nv;
    nv = 0;
    if (rst_n) begin
      for (int u = 0; u < NSRC; u++) begin
        if (dlv_valid[u]) begin
          nv++;
          if (lg_n < 1024) begin
            lg_cyc[lg_n]  = cyc;
            lg_unit[lg_n] = u;
            lg_data[lg_n] = dlv_data[u*DW +: DW];
            lg_fld[lg_n]  = {3'(u), dlv_slot[u*5 +: 5], dlv_iter[u*2 +: 2], dlv_opnd[u*2 +: 2]};
            lg_n++;
          end
        end
      end
      if (nv > 1) multi_hits++;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic do_reset();
    @(negedge clk);
    res_valid = '0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic set_src(input int s, input logic [31:0] d, input logic [1:0] n,
                         input logic [4*TW-1:0] t);
    res_data[s*DW +: DW]         = d;
    res_ncm1[s*2 +: 2]           = n;
    res_dst[s*MAXD*TW +: MAXD*TW] = t;
    res_valid[s]                 = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    int base, c0;
    int acc [NSRC];
    int nxt [NSRC];
    bit rdy_prev [NSRC];
    bit saw_full [NSRC];
    bit ok;

    // R1: reset state
    do_reset();
    check(res_ready == '1, "R1 ready after reset", res_ready, 8'hFF);
    check(dlv_valid == '0, "R1 no delivery after reset", dlv_valid, 0);

    // Table walk: isolated results, fields, expansion order and latency
    for (int v = 0; v < 5; v++) begin
      base = lg_n;
      @(negedge clk);
      set_src(VEC[v].src, VEC[v].data, VEC[v].ncm1, VEC[v].dst);
      c0 = cyc;
      @(negedge clk);
      res_valid = '0;
      repeat (8) @(negedge clk);
      check(lg_n - base == int'(VEC[v].ncm1) + 1, "R4 packet count", lg_n - base, VEC[v].ncm1 + 1);
      for (int k = 0; k <= int'(VEC[v].ncm1); k++) begin
        logic [11:0] et;
        et = VEC[v].dst[k*TW +: TW];
        check(lg_fld[base+k] == et, "R3 R4 tag fields in list order", lg_fld[base+k], et);
        check(lg_data[base+k] == VEC[v].data, "R3 delivered value", lg_data[base+k], VEC[v].data);
        check(lg_cyc[base+k] == c0 + 2 + k, "R5 delivery cycle", lg_cyc[base+k], c0 + 2 + k);
      end
    end

    // R7: round-robin order, from reset pointer
    do_reset();
    base = lg_n;
    @(negedge clk);
    set_src(5, 32'h55, 2'd0, {36'h0, 3'd1, 9'h0});
    set_src(2, 32'h22, 2'd0, {36'h0, 3'd1, 9'h0});
    set_src(7, 32'h77, 2'd0, {36'h0, 3'd1, 9'h0});
    @(negedge clk);
    res_valid = '0;
    repeat (6) @(negedge clk);
    ok = (lg_n - base == 3) && lg_data[base] == 32'h22 && lg_data[base+1] == 32'h55
         && lg_data[base+2] == 32'h77;
    check(ok, "R7 order 2,5,7 after reset", {lg_data[base][7:0], lg_data[base+1][7:0], lg_data[base+2][7:0]}, 24'h225577);
    base = lg_n;
    @(negedge clk);
    set_src(7, 32'h77, 2'd0, {36'h0, 3'd1, 9'h0});
    set_src(0, 32'h00, 2'd0, {36'h0, 3'd1, 9'h0});
    @(negedge clk);
    res_valid = '0;
    repeat (6) @(negedge clk);
    ok = (lg_n - base == 2) && lg_data[base] == 32'h00 && lg_data[base+1] == 32'h77;
    check(ok, "R7 wrap order 0,7", {lg_data[base][7:0], lg_data[base+1][7:0]}, 16'h0077);
    base = lg_n;
    @(negedge clk);
    set_src(2, 32'h22, 2'd1, {24'h0, {3'd6, 9'h0}, {3'd3, 9'h0}});
    set_src(4, 32'h44, 2'd0, {36'h0, 3'd5, 9'h0});
    @(negedge clk);
    res_valid = '0;
    repeat (6) @(negedge clk);
    ok = (lg_n - base == 3) && lg_data[base] == 32'h22 && lg_unit[base] == 3
         && lg_data[base+1] == 32'h44 && lg_data[base+2] == 32'h22 && lg_unit[base+2] == 6;
    check(ok, "R7 interleave mid-expansion", {lg_data[base][7:0], lg_data[base+1][7:0], lg_data[base+2][7:0]}, 24'h224422);

    // R1: reset with a result queued discards it
    base = lg_n;
    @(negedge clk);
    set_src(4, 32'h4444, 2'd3, {48'h0});
    @(negedge clk);
    res_valid = '0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(lg_n == base, "R1 queued result dropped by reset", lg_n - base, 0);
    check(res_ready == '1, "R1 ready after mid-run reset", res_ready, 8'hFF);

    // Saturation: all sources push every cycle
    do_reset();
    base = lg_n;
    for (int s = 0; s < NSRC; s++) begin
      acc[s] = 0; nxt[s] = 0; rdy_prev[s] = 1'b0; saw_full[s] = 1'b0;
    end
    for (int t = 0; t < 61; t++) begin
      @(negedge clk);
      for (int s = 0; s < NSRC; s++) begin
        if (res_valid[s] && rdy_prev[s]) acc[s]++;
        if (t < 60) begin
          set_src(s, {8'(s), 24'(acc[s])}, 2'd0, {36'h0, 3'((s + 3) % NSRC), 5'(s), 4'h0});
          rdy_prev[s] = res_ready[s];
          if (!res_ready[s]) saw_full[s] = 1'b1;
        end
      end
    end
    res_valid = '0;
    repeat (60) @(negedge clk);
    ok = 1'b1;
    for (int s = 0; s < NSRC; s++) ok = ok && saw_full[s];
    check(ok, "R2 ready drops when queue full", 0, 1);
    ok = 1'b1;
    for (int i = base; i < base + 40; i++)
      if (lg_data[i+1][31:24] != 8'((int'(lg_data[i][31:24]) + 1) % NSRC)) ok = 1'b0;
    check(ok, "R7 saturated rotation", 0, 1);
    for (int i = base; i < lg_n; i++) begin
      int s;
      s = int'(lg_data[i][31:24]);
      if (s < NSRC) begin
        if (int'(lg_data[i][23:0]) != nxt[s] || lg_unit[i] != (s + 3) % NSRC) nxt[s] = -10000;
        else nxt[s]++;
      end
    end
    for (int s = 0; s < NSRC; s++)
      check(nxt[s] == acc[s], "R8 R9 R2 per-source delivery count and order", nxt[s], acc[s]);
    check(multi_hits == 0, "R6 one delivery per cycle", multi_hits, 0);

    finish_run();
  end
endmodule